// File: doc/BRIEF.md
# Load Value Predictor with Predictability Classifier

This block guesses the data a load will return before memory answers. A direct-mapped value table, indexed by a hash of the load's instruction address and carrying no tags, keeps the last value each entry has seen. Beside it, a table of 2-bit saturating counters judges how trustworthy that guess is. The counter moves up on each correct guess and down on each wrong one. From its state the block decides whether the pipeline should use the guess, and whether the load may be treated as constant so that it skips verification against the cache.

Each verify reports a load's instruction address, its actual data and its memory address. The verify updates the counter, then overwrites the stored value. A load promoted to constant has its memory address recorded in a small tracking table. Every store address is compared against that table, and a match takes constant status away from the load before it can return a stale value. The lookup path is combinational from state; every update shows on the outputs after the next rising clock edge.

Top module: `ldval_pred`

## Requirements
- R1: After reset every value entry reads zero and every counter is 0, so a lookup of any address returns value 0 with use and constant both low.
- R2: The table index is the XOR of the consecutive IDX_W-bit slices of the word-address PC, zero-extended to a whole number of slices. Two PCs with the same index share one value entry and one counter: no tag is compared.
- R3: A verify always overwrites the value entry at its index with the actual data, whether or not the stored value matched. A lookup at that index returns the new value from the following cycle.
- R4: A verify whose data equals the stored value raises the counter by one, saturating at 3. A verify whose data differs lowers the counter by one, saturating at 0.
- R5: pred_use_o is high when the looked-up counter is 2 or 3. pred_const_o is high only when it is 3.
- R6: A counter can enter or stay at 3 only if the tracking table already holds its index or has a free slot. When all CONST_N slots hold other indices, a correct verify leaves the counter at 2.
- R7: A store whose address equals the recorded load address of a constant entry sets that counter to 2 on the next cycle and frees its slot. A store to any other address changes nothing.
- R8: A verify in the same cycle as any store never leaves its counter at 3.
- R9: Any verify that leaves a counter below 3 frees that index's slot, so a waiting load can then be promoted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | Word address of the load being predicted |
| pred_val_o | output | DATA_W | Predicted load data |
| pred_use_o | output | 1 | The prediction should be used |
| pred_const_o | output | 1 | The load is classed constant and may skip verification |
| vfy_valid_i | input | 1 | A verify is presented this cycle |
| vfy_pc_i | input | PC_W | Word address of the verified load |
| vfy_val_i | input | DATA_W | Data the load actually returned |
| vfy_addr_i | input | ADDR_W | Memory address the load read |
| st_valid_i | input | 1 | A store address is presented this cycle |
| st_addr_i | input | ADDR_W | Address written by the store |

## Verification
The bench builds the block with an 8-entry table (IDX_W=3), an 8-bit word-address PC, 16-bit data and addresses, and only two tracking slots (CONST_N=2). The narrow PC puts an aliasing pair within reach: word addresses 0x01 and 0x08 both fold to index 1. Two slots let a third candidate find the tracking table full, so the bench can show the counter held at 2 and then promoted once a wrong verify frees a slot. Store snoops are tested with matching and unrelated addresses, and also in the same cycle as a verify.

// File: rtl/ldval_pkg.sv
package ldval_pkg;
  typedef logic [1:0] cls_t;
  localparam cls_t CLS_NONE  = 2'd0;
  localparam cls_t CLS_WEAK  = 2'd1;
  localparam cls_t CLS_PRED  = 2'd2;
  localparam cls_t CLS_CONST = 2'd3;
endpackage

// File: rtl/ldval_value_tbl.sv
module ldval_value_tbl #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_val_o,
  input  logic [IDX_W-1:0]  chk_idx_i,
  output logic [DATA_W-1:0] chk_val_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_val_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_val_i;
    end
  end

  assign rd_val_o  = mem_q[rd_idx_i];
  assign chk_val_o = mem_q[chk_idx_i];

  AST_VT_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_val_i)); // R3
endmodule

// File: rtl/ldval_cls_tbl.sv
module ldval_cls_tbl
  import ldval_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output cls_t                   rd_cls_o,
  input  logic                   vfy_en_i,
  input  logic [IDX_W-1:0]       vfy_idx_i,
  input  logic                   hit_i,
  input  logic                   grant_i,
  output logic                   promote_o,
  input  logic [(1<<IDX_W)-1:0]  demote_i
);
  localparam int DEPTH = 1 << IDX_W;

  cls_t ctr_q [DEPTH];
  cls_t cur, step;

  always_comb begin
    cur = ctr_q[vfy_idx_i];
    if (hit_i) step = (cur == CLS_CONST) ? CLS_CONST : cur + 2'd1;
    else       step = (cur == CLS_NONE)  ? CLS_NONE  : cur - 2'd1;
    // constant status only with a tracking slot
    if (step == CLS_CONST && !grant_i) step = CLS_PRED;
  end

  assign promote_o = vfy_en_i && hit_i && (cur >= CLS_PRED);
  assign rd_cls_o  = ctr_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CLS_NONE;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vfy_en_i && vfy_idx_i == IDX_W'(i)) ctr_q[i] <= step;
        else if (demote_i[i])                   ctr_q[i] <= CLS_PRED;
      end
    end
  end

  AST_HIT_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_en_i && hit_i && grant_i |=> ctr_q[$past(vfy_idx_i)] >= $past(cur)); // R4
  AST_MISS_LOSES_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_en_i && !hit_i |=> ctr_q[$past(vfy_idx_i)] != CLS_CONST); // R4
  AST_NO_UNTRACKED_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_en_i && !grant_i |=> ctr_q[$past(vfy_idx_i)] != CLS_CONST); // R6
endmodule

// File: rtl/ldval_const_tbl.sv
module ldval_const_tbl #(
  parameter int IDX_W   = 6,
  parameter int ADDR_W  = 32,
  parameter int CONST_N = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vfy_en_i,
  input  logic [IDX_W-1:0]      vfy_idx_i,
  input  logic [ADDR_W-1:0]     vfy_addr_i,
  input  logic                  promote_i,
  input  logic                  st_en_i,
  input  logic [ADDR_W-1:0]     st_addr_i,
  output logic                  grant_o,
  output logic [(1<<IDX_W)-1:0] demote_o
);
  localparam int SLOT_W = (CONST_N > 1) ? $clog2(CONST_N) : 1;

  logic [CONST_N-1:0] valid_q, match_w, st_hit_w;
  logic [IDX_W-1:0]   idx_q  [CONST_N];
  logic [ADDR_W-1:0]  addr_q [CONST_N];
  logic [SLOT_W-1:0]  free_sel;
  logic               any_free, take;

  always_comb begin
    any_free = 1'b0;
    free_sel = '0;
    demote_o = '0;
    for (int k = CONST_N - 1; k >= 0; k--) begin
      match_w[k]  = valid_q[k] && (idx_q[k] == vfy_idx_i);
      st_hit_w[k] = st_en_i && valid_q[k] && (addr_q[k] == st_addr_i);
      if (!valid_q[k]) begin
        any_free = 1'b1;
        free_sel = SLOT_W'(k);
      end
      if (st_hit_w[k]) demote_o[idx_q[k]] = 1'b1;
    end
  end

  // any store in the cycle blocks promotion
  assign grant_o = !st_en_i && ((|match_w) || any_free);
  assign take    = vfy_en_i && promote_i && grant_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int k = 0; k < CONST_N; k++) begin
        idx_q[k]  <= '0;
        addr_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < CONST_N; k++) begin
        if (take && ((|match_w) ? match_w[k] : (free_sel == SLOT_W'(k)))) begin
          valid_q[k] <= 1'b1;
          idx_q[k]   <= vfy_idx_i;
          addr_q[k]  <= vfy_addr_i;
        end else if (st_hit_w[k] || (vfy_en_i && match_w[k])) begin
          valid_q[k] <= 1'b0;
        end
      end
    end
  end

  for (genvar k = 0; k < CONST_N; k++) begin : g_chk
    AST_STORE_FREES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_hit_w[k] |=> !valid_q[k]); // R7
  end
endmodule

// File: rtl/ldval_pred.sv
module ldval_pred
  import ldval_pkg::*;
#(
  parameter int PC_W    = 30,
  parameter int IDX_W   = 6,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int CONST_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic [DATA_W-1:0] pred_val_o,
  output logic              pred_use_o,
  output logic              pred_const_o,
  input  logic              vfy_valid_i,
  input  logic [PC_W-1:0]   vfy_pc_i,
  input  logic [DATA_W-1:0] vfy_val_i,
  input  logic [ADDR_W-1:0] vfy_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int SLICES = (PC_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = SLICES * IDX_W;

  logic [PAD_W-1:0]  lk_pad, vf_pad;
  logic [IDX_W-1:0]  lk_idx, vf_idx;
  logic [DATA_W-1:0] vf_old;
  logic              hit, grant, promote;
  logic [DEPTH-1:0]  demote;
  cls_t              lk_cls;

  assign lk_pad = PAD_W'(lookup_pc_i);
  assign vf_pad = PAD_W'(vfy_pc_i);

  always_comb begin
    lk_idx = '0;
    vf_idx = '0;
    for (int s = 0; s < SLICES; s++) begin
      lk_idx ^= lk_pad[s*IDX_W +: IDX_W];
      vf_idx ^= vf_pad[s*IDX_W +: IDX_W];
    end
  end

  ldval_value_tbl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_vt (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_val_o(pred_val_o),
    .chk_idx_i(vf_idx), .chk_val_o(vf_old),
    .wr_en_i(vfy_valid_i), .wr_idx_i(vf_idx), .wr_val_i(vfy_val_i)
  );

  assign hit = (vf_old == vfy_val_i);

  ldval_cls_tbl #(.IDX_W(IDX_W)) u_cls (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_cls_o(lk_cls),
    .vfy_en_i(vfy_valid_i), .vfy_idx_i(vf_idx), .hit_i(hit),
    .grant_i(grant), .promote_o(promote), .demote_i(demote)
  );

  ldval_const_tbl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CONST_N(CONST_N)) u_ct (
    .clk_i, .rst_ni,
    .vfy_en_i(vfy_valid_i), .vfy_idx_i(vf_idx), .vfy_addr_i(vfy_addr_i),
    .promote_i(promote), .st_en_i(st_valid_i), .st_addr_i(st_addr_i),
    .grant_o(grant), .demote_o(demote)
  );

  assign pred_use_o   = (lk_cls >= CLS_PRED);
  assign pred_const_o = (lk_cls == CLS_CONST);

  AST_STORE_BLOCKS_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_valid_i && st_valid_i && (lookup_pc_i == vfy_pc_i)
      |=> !pred_const_o || !$stable(lookup_pc_i)); // R8
endmodule

// File: tb/ldval_pred_tb.sv
module ldval_pred_tb_top;
  localparam int PC_W = 8, IDX_W = 3, DATA_W = 16, ADDR_W = 16, CONST_N = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [PC_W-1:0]   lookup_pc_i = '0;
  logic [DATA_W-1:0] pred_val_o;
  logic              pred_use_o, pred_const_o;
  logic              vfy_valid_i = 1'b0;
  logic [PC_W-1:0]   vfy_pc_i = '0;
  logic [DATA_W-1:0] vfy_val_i = '0;
  logic [ADDR_W-1:0] vfy_addr_i = '0;
  logic              st_valid_i = 1'b0;
  logic [ADDR_W-1:0] st_addr_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldval_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .CONST_N(CONST_N)) dut_i (
    .clk_i(clk), .rst_ni, .lookup_pc_i, .pred_val_o, .pred_use_o, .pred_const_o,
    .vfy_valid_i, .vfy_pc_i, .vfy_val_i, .vfy_addr_i, .st_valid_i, .st_addr_i
  );

  task automatic look(input logic [PC_W-1:0] pc, input logic [DATA_W-1:0] ev,
                      input bit eu, input bit ec, input string req);
    lookup_pc_i = pc;
    #1;
    checks++;
    if (pred_val_o !== ev || pred_use_o !== eu || pred_const_o !== ec) begin
      errors++;
      $display("FAIL %s pc=%h: got val=%h use=%b const=%b, expected val=%h use=%b const=%b",
               req, pc, pred_val_o, pred_use_o, pred_const_o, ev, eu, ec);
    end
  endtask

  task automatic step(input bit v, input logic [PC_W-1:0] pc, input logic [DATA_W-1:0] val,
                      input logic [ADDR_W-1:0] a, input bit s, input logic [ADDR_W-1:0] sa);
    @(negedge clk);
    vfy_valid_i = v; vfy_pc_i = pc; vfy_val_i = val; vfy_addr_i = a;
    st_valid_i = s;  st_addr_i = sa;
    @(negedge clk);
    vfy_valid_i = 1'b0; st_valid_i = 1'b0;
  endtask

  task automatic verify(input logic [PC_W-1:0] pc, input logic [DATA_W-1:0] val,
                        input logic [ADDR_W-1:0] a);
    step(1'b1, pc, val, a, 1'b0, '0);
  endtask

  task automatic store(input logic [ADDR_W-1:0] sa);
    step(1'b0, '0, '0, '0, 1'b1, sa);
  endtask

  // miss from 0, then three hits: counter 0,1,2,3
  task automatic promote4(input logic [PC_W-1:0] pc, input logic [DATA_W-1:0] val,
                          input logic [ADDR_W-1:0] a);
    for (int i = 0; i < 4; i++) verify(pc, val, a);
  endtask

  task automatic t_reset();
    look(8'h07, 16'h0, 1'b0, 1'b0, "R1");
    look(8'h01, 16'h0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_train();
    verify(8'h01, 16'h1234, 16'h0100);
    look(8'h01, 16'h1234, 1'b0, 1'b0, "R3");            // miss, ctr 0
    verify(8'h01, 16'h1234, 16'h0100);
    look(8'h01, 16'h1234, 1'b0, 1'b0, "R4");            // ctr 1
    verify(8'h01, 16'h1234, 16'h0100);
    look(8'h01, 16'h1234, 1'b1, 1'b0, "R5");            // ctr 2
    verify(8'h01, 16'h1234, 16'h0100);
    look(8'h01, 16'h1234, 1'b1, 1'b1, "R5");            // ctr 3
    verify(8'h01, 16'h1234, 16'h0100);
    look(8'h01, 16'h1234, 1'b1, 1'b1, "R4");            // saturates at 3
  endtask

  task automatic t_alias();
    look(8'h08, 16'h1234, 1'b1, 1'b1, "R2");            // 0x08 folds to index 1
    verify(8'h08, 16'h5555, 16'h0100);
    look(8'h01, 16'h5555, 1'b1, 1'b0, "R2");            // shared entry, ctr 2
    look(8'h08, 16'h5555, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_low();
    verify(8'h02, 16'h0007, 16'h0);
    verify(8'h02, 16'h0009, 16'h0);
    look(8'h02, 16'h0009, 1'b0, 1'b0, "R4");            // floor at 0
    verify(8'h02, 16'h0009, 16'h0);
    look(8'h02, 16'h0009, 1'b0, 1'b0, "R4");            // ctr 1 after floor
  endtask

  task automatic t_store();
    verify(8'h01, 16'h5555, 16'h0200);
    look(8'h01, 16'h5555, 1'b1, 1'b1, "R7");
    store(16'h0300);
    look(8'h01, 16'h5555, 1'b1, 1'b1, "R7");            // unrelated store
    store(16'h0200);
    look(8'h01, 16'h5555, 1'b1, 1'b0, "R7");            // demoted to 2
  endtask

  task automatic t_same_cycle();
    verify(8'h06, 16'h0066, 16'h0060);
    verify(8'h06, 16'h0066, 16'h0060);
    verify(8'h06, 16'h0066, 16'h0060);
    look(8'h06, 16'h0066, 1'b1, 1'b0, "R8");
    step(1'b1, 8'h06, 16'h0066, 16'h0060, 1'b1, 16'h0999);
    look(8'h06, 16'h0066, 1'b1, 1'b0, "R8");            // capped by store
    verify(8'h06, 16'h0066, 16'h0060);
    look(8'h06, 16'h0066, 1'b1, 1'b1, "R8");
    store(16'h0060);
    look(8'h06, 16'h0066, 1'b1, 1'b0, "R7");            // frees slot again
  endtask

  task automatic t_full();
    promote4(8'h03, 16'h000A, 16'h0010);
    promote4(8'h04, 16'h000B, 16'h0020);
    look(8'h03, 16'h000A, 1'b1, 1'b1, "R6");
    look(8'h04, 16'h000B, 1'b1, 1'b1, "R6");
    promote4(8'h05, 16'h000C, 16'h0030);
    look(8'h05, 16'h000C, 1'b1, 1'b0, "R6");            // no free slot
    verify(8'h03, 16'h00AA, 16'h0010);
    look(8'h03, 16'h00AA, 1'b1, 1'b0, "R9");            // slot freed
    verify(8'h05, 16'h000C, 16'h0030);
    look(8'h05, 16'h000C, 1'b1, 1'b1, "R9");            // now promoted
    store(16'h0010);
    look(8'h05, 16'h000C, 1'b1, 1'b1, "R7");            // stale address no effect
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_train();
    t_alias();
    t_low();
    t_store();
    t_same_cycle();
    t_full();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule